// File: doc/BRIEF.md
# Pretrigger Capture Controller

This block steers a single buffered acquisition into an on-chip sample RAM. After a start command with a valid configuration it writes every accepted sample to a circular region of the RAM, wrapping at the programmed depth, while it waits for a trigger. It accepts a trigger only once the programmed number of pretrigger samples has been stored. From the trigger sample onward it stores exactly the remaining (depth − pretrigger) samples, stops writing, and reports the capture as complete.

The trigger condition comes from two external trigger units. Each can be enabled on its own, and when both are enabled an AND or OR combination is chosen. With neither enabled the capture triggers as soon as the pretrigger quota is met. When the capture is complete, a readout start address points at the oldest stored sample, so a reader that walks the buffer from there, wrapping at the depth, sees the samples in time order. The controller drives only the RAM address and write enable. The sample data goes to the RAM directly, in the same cycle.

Top module: `pretrig_capture_ctrl`

## Requirements
- R1: After reset `cap_status` is 0, `buf_we` is 0 and `cfg_err` is 0.
- R2: A `start` pulse with a valid configuration clears `cfg_err`, makes `cap_status` 0 from the next cycle, and restarts the fill at address 0. It does this even in the middle of a capture or after one has completed. A sample presented in the start cycle is not written.
- R3: A configuration is valid only when `cfg_depth` is a multiple of BLK (512), lies between MIN_DEPTH (2048) and 2^ADDR_W (4096), and `cfg_pre` is below `cfg_depth`. A start with an invalid configuration sets `cfg_err` to 1 in the next cycle, and no sample is written until the next start.
- R4: While a capture is running, each cycle with `smp_valid` high writes one sample: `buf_we` is 1 in that same cycle. Successive write addresses run 0, 1, 2, … and wrap from depth−1 back to 0.
- R5: Trigger mode bit 0 enables unit A (`trig_a`) and bit 1 enables unit B (`trig_b`). With one unit enabled only that unit counts. With both enabled, bit 2 set to 0 means A OR B and set to 1 means A AND B. The trigger inputs are looked at only in cycles with `smp_valid` high.
- R6: With bits 1:0 of the trigger mode both 0, the trigger condition is always true, whatever the trigger inputs do.
- R7: A trigger is accepted on a sample only if at least `cfg_pre` samples were stored before it in the current capture. An earlier trigger condition is ignored.
- R8: The accepted trigger sample and the samples after it together number exactly depth − pretrigger. After the last of them is written, `cap_status` becomes 2 in the next cycle, and it is 0 before that.
- R9: When `cap_status` is 2, `rd_start` holds the address of the oldest stored sample, which is the address after the last one written, wrapped at the depth.
- R10: Once `cap_status` is 2 it stays 2 until the next start, and samples arriving in that time are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start (or restart) pulse; latches the configuration |
| cfg_depth | input | ADDR_W+1 | Total samples to capture |
| cfg_pre | input | ADDR_W+1 | Samples to keep ahead of the trigger |
| cfg_trig_mode | input | 3 | bit0 enable A, bit1 enable B, bit2 0=OR 1=AND |
| smp_valid | input | 1 | A sample is present in this cycle |
| trig_a | input | 1 | Trigger unit A condition |
| trig_b | input | 1 | Trigger unit B condition |
| buf_we | output | 1 | RAM write enable |
| buf_addr | output | ADDR_W | RAM write address |
| rd_start | output | ADDR_W | Address of the oldest sample once complete |
| cap_status | output | 2 | 0 while idle or running, 2 when complete |
| cfg_err | output | 1 | Last start carried an invalid configuration |

## Verification
Two pairs of functions can meet in one cycle. The first is a start command arriving together with a valid sample: the bench presents a sample in the start cycle of a capture that is already running and expects that sample not to be written, with the fill restarting at address 0. The second is a trigger that first becomes true in the same sample that completes the pretrigger quota: the bench asserts the trigger inputs from sample 0 and checks, through the exact cycle in which the status turns to 2 and the full ordered list of write addresses, that the trigger was taken at that boundary sample and not earlier or later. Cycles with no valid sample carry active trigger inputs, to show that those inputs are ignored.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_PRE  = 2'd1,
      CAP_POST = 2'd2,
      CAP_DONE = 2'd3
   } cap_state_e;

   localparam logic [1:0] STAT_BUSY = 2'd0;
   localparam logic [1:0] STAT_DONE = 2'd2;

   // trigger mode field positions
   localparam int unsigned MODE_EN_A = 0;
   localparam int unsigned MODE_EN_B = 1;
   localparam int unsigned MODE_AND  = 2;

endpackage

// File: rtl/pcap_cfg_check.sv
module pcap_cfg_check #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BLK       = 512,
   parameter int unsigned MIN_DEPTH = 2048
) (
   input  logic [ADDR_W:0] depth,
   input  logic [ADDR_W:0] pre,
   output logic            ok
);

   localparam int unsigned CNT_W     = ADDR_W + 1;
   localparam int unsigned BLK_LG    = $clog2(BLK);
   localparam int unsigned MAX_DEPTH = 1 << ADDR_W;

   logic aligned;
   logic in_range;
   logic pre_fits;

   generate
      if ((BLK & (BLK - 1)) != 0) begin : g_blk_bad
         $error("BLK must be a power of two");
      end
      if ((MIN_DEPTH % BLK) != 0 || MIN_DEPTH == 0) begin : g_min_bad
         $error("MIN_DEPTH must be a nonzero multiple of BLK");
      end
      if (MIN_DEPTH > MAX_DEPTH) begin : g_max_bad
         $error("MIN_DEPTH exceeds the buffer size");
      end

      if (BLK_LG == 0) begin : g_any_align
         assign aligned = 1'b1;
      end else begin : g_blk_align
         assign aligned = (depth[BLK_LG-1:0] == '0);
      end
   endgenerate

   assign in_range = (depth >= CNT_W'(MIN_DEPTH)) && (depth <= CNT_W'(MAX_DEPTH));
   assign pre_fits = (pre < depth);
   assign ok       = aligned && in_range && pre_fits;

endmodule

// File: rtl/pcap_trig_merge.sv
module pcap_trig_merge #(
   parameter int unsigned NUM_SRC = 2
) (
   input  logic [NUM_SRC-1:0] trig_in,
   input  logic [NUM_SRC-1:0] trig_en,
   input  logic               and_mode,
   output logic               hit
);

   logic [NUM_SRC-1:0] pass_and;
   logic [NUM_SRC-1:0] pass_or;
   logic               any_en;

   generate
      if (NUM_SRC < 1) begin : g_src_bad
         $error("NUM_SRC must be at least 1");
      end
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         // a disabled source neither blocks an AND nor feeds an OR
         assign pass_and[i] = !trig_en[i] || trig_in[i];
         assign pass_or[i]  =  trig_en[i] && trig_in[i];
      end
   endgenerate

   assign any_en = |trig_en;

   always_comb begin
      if (!any_en) begin
         hit = 1'b1;
      end else if (and_mode) begin
         hit = &pass_and;
      end else begin
         hit = |pass_or;
      end
   end

endmodule

// File: rtl/pcap_ring_ptr.sv
module pcap_ring_ptr #(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [ADDR_W:0]   limit,
   output logic [ADDR_W-1:0] ptr
);

   localparam int unsigned CNT_W = ADDR_W + 1;

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_nxt;
   logic              at_end;

   assign at_end  = ({1'b0, ptr_q} == (limit - CNT_W'(1)));
   assign ptr_nxt = at_end ? '0 : ptr_q + ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (clr) begin
         ptr_q <= '0;
      end else if (adv) begin
         ptr_q <= ptr_nxt;
      end
   end

   assign ptr = ptr_q;

endmodule

// File: rtl/pcap_seq.sv
module pcap_seq
   import pcap_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            cfg_ok,
   input  logic [ADDR_W:0] cfg_depth,
   input  logic [ADDR_W:0] cfg_pre,
   input  logic            smp_valid,
   input  logic            trig_hit,
   output logic            accept,
   output logic            ring_clr,
   output logic [ADDR_W:0] depth_q,
   output logic            done,
   output logic            err
);

   localparam int unsigned CNT_W = ADDR_W + 1;

   cap_state_e       state_q;
   logic [CNT_W-1:0] pre_q;
   logic [CNT_W-1:0] fill_q;
   logic [CNT_W-1:0] post_q;
   logic [CNT_W-1:0] post_len;
   logic             err_q;
   logic             running;
   logic             trig_take;

   assign running   = (state_q == CAP_PRE) || (state_q == CAP_POST);
   assign accept    = smp_valid && !start && running;
   assign ring_clr  = start && cfg_ok;
   assign post_len  = depth_q - pre_q;
   assign trig_take = (state_q == CAP_PRE) && (fill_q >= pre_q) && trig_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CAP_IDLE;
         depth_q <= '0;
         pre_q   <= '0;
         fill_q  <= '0;
         post_q  <= '0;
         err_q   <= 1'b0;
      end else if (start) begin
         if (cfg_ok) begin
            state_q <= CAP_PRE;
            depth_q <= cfg_depth;
            pre_q   <= cfg_pre;
            fill_q  <= '0;
            post_q  <= '0;
            err_q   <= 1'b0;
         end else begin
            state_q <= CAP_IDLE;
            err_q   <= 1'b1;
         end
      end else if (accept) begin
         unique case (state_q)
            CAP_PRE: begin
               if (trig_take) begin
                  if (post_len == CNT_W'(1)) begin
                     state_q <= CAP_DONE;
                  end else begin
                     state_q <= CAP_POST;
                     post_q  <= post_len - CNT_W'(1);
                  end
               end else if (fill_q < pre_q) begin
                  fill_q <= fill_q + CNT_W'(1);
               end
            end
            CAP_POST: begin
               post_q <= post_q - CNT_W'(1);
               if (post_q == CNT_W'(1)) begin
                  state_q <= CAP_DONE;
               end
            end
            default: begin
               state_q <= state_q;
            end
         endcase
      end
   end

   assign done = (state_q == CAP_DONE);
   assign err  = err_q;

endmodule

// File: rtl/pretrig_capture_ctrl.sv
module pretrig_capture_ctrl
   import pcap_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned BLK       = 512,
   parameter int unsigned MIN_DEPTH = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W:0]   cfg_depth,
   input  logic [ADDR_W:0]   cfg_pre,
   input  logic [2:0]        cfg_trig_mode,
   input  logic              smp_valid,
   input  logic              trig_a,
   input  logic              trig_b,
   output logic              buf_we,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [ADDR_W-1:0] rd_start,
   output logic [1:0]        cap_status,
   output logic              cfg_err
);

   localparam int unsigned NUM_SRC = 2;

   logic              cfg_ok;
   logic              trig_hit;
   logic              accept;
   logic              ring_clr;
   logic              done;
   logic [ADDR_W:0]   depth_q;
   logic [ADDR_W-1:0] wr_ptr;
   logic [2:0]        mode_q;

   // the mode is latched with the rest of the configuration
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (start && cfg_ok) begin
         mode_q <= cfg_trig_mode;
      end
   end

   pcap_cfg_check #(
      .ADDR_W    (ADDR_W),
      .BLK       (BLK),
      .MIN_DEPTH (MIN_DEPTH)
   ) u_cfg (
      .depth (cfg_depth),
      .pre   (cfg_pre),
      .ok    (cfg_ok)
   );

   pcap_trig_merge #(
      .NUM_SRC (NUM_SRC)
   ) u_merge (
      .trig_in  ({trig_b, trig_a}),
      .trig_en  ({mode_q[MODE_EN_B], mode_q[MODE_EN_A]}),
      .and_mode (mode_q[MODE_AND]),
      .hit      (trig_hit)
   );

   pcap_seq #(
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_ok    (cfg_ok),
      .cfg_depth (cfg_depth),
      .cfg_pre   (cfg_pre),
      .smp_valid (smp_valid),
      .trig_hit  (trig_hit),
      .accept    (accept),
      .ring_clr  (ring_clr),
      .depth_q   (depth_q),
      .done      (done),
      .err       (cfg_err)
   );

   pcap_ring_ptr #(
      .ADDR_W (ADDR_W)
   ) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ring_clr),
      .adv   (accept),
      .limit (depth_q),
      .ptr   (wr_ptr)
   );

   assign buf_we     = accept;
   assign buf_addr   = wr_ptr;
   assign rd_start   = wr_ptr;
   assign cap_status = done ? STAT_DONE : STAT_BUSY;

endmodule

// File: rtl/pretrig_capture_ctrl_chk.sv
module pretrig_capture_ctrl_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              buf_we,
   input logic [ADDR_W-1:0] buf_addr,
   input logic [1:0]        cap_status,
   input logic              cfg_err,
   input logic [ADDR_W:0]   depth_q
);

   logic              prev_vld;
   logic [ADDR_W-1:0] prev_addr;
   logic [ADDR_W:0]   step_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_vld  <= 1'b0;
         prev_addr <= '0;
      end else if (start) begin
         prev_vld  <= 1'b0;
      end else if (buf_we) begin
         prev_vld  <= 1'b1;
         prev_addr <= buf_addr;
      end
   end

   assign step_addr = ({1'b0, prev_addr} + 1'b1 == depth_q) ? '0 : {1'b0, prev_addr} + 1'b1;

   // R10
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_status == 2'd2 && !start) |=> cap_status == 2'd2);

   // R10
   no_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_status == 2'd2 |-> !buf_we);

   // R4
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> ({1'b0, buf_addr} < depth_q));

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && prev_vld) |-> ({1'b0, buf_addr} == step_addr));

   // R3
   cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (!buf_we && cap_status == 2'd0));

   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> cap_status == 2'd0);

   // R2
   start_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !buf_we);

endmodule

bind pretrig_capture_ctrl pretrig_capture_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .buf_we     (buf_we),
   .buf_addr   (buf_addr),
   .cap_status (cap_status),
   .cfg_err    (cfg_err),
   .depth_q    (depth_q)
);

// File: tb/pretrig_capture_ctrl_tb.sv
`timescale 1ns/1ps
module pretrig_capture_ctrl_tb;

   localparam int ADDR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ADDR_W:0]   cfg_depth = '0;
   logic [ADDR_W:0]   cfg_pre = '0;
   logic [2:0]        cfg_trig_mode = '0;
   logic              smp_valid = 1'b0;
   logic              trig_a = 1'b0;
   logic              trig_b = 1'b0;
   logic              buf_we;
   logic [ADDR_W-1:0] buf_addr;
   logic [ADDR_W-1:0] rd_start;
   logic [1:0]        cap_status;
   logic              cfg_err;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int exp_q[$];

   always #2.5 clk = ~clk;

   pretrig_capture_ctrl u_dut (
      .clk (clk), .rst_n (rst_n), .start (start),
      .cfg_depth (cfg_depth), .cfg_pre (cfg_pre), .cfg_trig_mode (cfg_trig_mode),
      .smp_valid (smp_valid), .trig_a (trig_a), .trig_b (trig_b),
      .buf_we (buf_we), .buf_addr (buf_addr), .rd_start (rd_start),
      .cap_status (cap_status), .cfg_err (cfg_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: every write must match the next expected address
   always @(negedge clk) begin
      if (rst_n && buf_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10/R3 write with none expected", int'(buf_addr), -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            check(int'(buf_addr) == e, "R4 write address", int'(buf_addr), e);
         end
      end
   end

   function automatic bit model_hit(input int mode, input bit ta, input bit tb);
      bit ea = mode[0];
      bit eb = mode[1];
      if (!ea && !eb) return 1'b1;
      if (ea && eb) return mode[2] ? (ta && tb) : (ta || tb);
      return ea ? ta : tb;
   endfunction

   task automatic run_capture(input int depth, input int pre, input int mode,
                              input int a_from, input int b_from,
                              input int max_smp, input bit valid_at_start,
                              input string tag);
      int  ptr = 0;
      int  fill = 0;
      int  post = 0;
      int  k = 0;
      bit  trig = 0;
      bit  done = 0;
      @(posedge clk); #1;
      start = 1'b1; cfg_depth = depth[ADDR_W:0]; cfg_pre = pre[ADDR_W:0];
      cfg_trig_mode = mode[2:0];
      smp_valid = valid_at_start; trig_a = 1'b1; trig_b = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      // R2: start clears status and error
      check(cap_status == 2'd0 && !cfg_err, {"R2 start ", tag}, int'(cap_status), 0);
      while (!done && k < max_smp) begin
         bit v;
         v = (cyc % 4) != 3;
         cyc++;
         // R8: not complete before the last sample
         check(cap_status == 2'd0, {"R8 early done ", tag}, int'(cap_status), 0);
         smp_valid = v;
         if (v) begin
            trig_a = (k >= a_from);
            trig_b = (k >= b_from);
            exp_q.push_back(ptr);
            ptr = (ptr + 1 == depth) ? 0 : ptr + 1;
            if (!trig) begin
               // R5 R6 R7: combine, then wait for the pretrigger quota
               if (fill >= pre && model_hit(mode, trig_a, trig_b)) begin
                  trig = 1'b1;
                  post = depth - pre;
               end else if (fill < pre) begin
                  fill++;
               end
            end
            if (trig) begin
               post--;
               if (post == 0) done = 1'b1;
            end
            k++;
         end else begin
            // R5: trigger inputs on idle cycles must be ignored
            trig_a = 1'b1;
            trig_b = 1'b1;
         end
         @(posedge clk); #1;
      end
      smp_valid = 1'b0;
      check(exp_q.size() == 0, {"R4 missing writes ", tag}, exp_q.size(), 0);
      if (done) begin
         check(cap_status == 2'd2, {"R8 done ", tag}, int'(cap_status), 2);
         check(int'(rd_start) == ptr, {"R9 oldest ", tag}, int'(rd_start), ptr);
         smp_valid = 1'b1;
         repeat (3) @(posedge clk);
         #1;
         smp_valid = 1'b0;
         check(cap_status == 2'd2, {"R10 sticky ", tag}, int'(cap_status), 2);
      end
      trig_a = 1'b0;
      trig_b = 1'b0;
   endtask

   task automatic bad_cfg(input int depth, input int pre, input string tag);
      @(posedge clk); #1;
      start = 1'b1; cfg_depth = depth[ADDR_W:0]; cfg_pre = pre[ADDR_W:0];
      cfg_trig_mode = 3'b000; smp_valid = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      check(cfg_err == 1'b1, {"R3 reject ", tag}, int'(cfg_err), 1);
      check(cap_status == 2'd0, {"R3 status ", tag}, int'(cap_status), 0);
      repeat (4) @(posedge clk);
      #1;
      smp_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(cap_status == 2'd0, "R1 status", int'(cap_status), 0);
      check(!buf_we, "R1 we", int'(buf_we), 0);
      check(!cfg_err, "R1 err", int'(cfg_err), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(cap_status == 2'd0 && !cfg_err, "R1 after release", int'(cap_status), 0);

      // R5 OR of both units
      run_capture(2048, 300, 3'b011, 700, 900, 100000, 0, "or");
      // R5 AND of both units (also R2 start after done)
      run_capture(2048, 300, 3'b111, 700, 900, 100000, 0, "and");
      // R5 only unit B counts
      run_capture(2048, 300, 3'b010, 100, 1500, 100000, 0, "onlyB");
      // R6 unconditional, AND bit set but no unit enabled
      run_capture(2048, 500, 3'b100, 99999, 99999, 100000, 0, "uncond");
      // R7 trigger true from the first sample, boundary at the quota
      run_capture(2048, 1000, 3'b001, 0, 99999, 100000, 0, "early");
      // R8 zero pretrigger, trigger on the very first sample
      run_capture(2048, 0, 3'b001, 0, 99999, 100000, 0, "pre0");
      // R8 full buffer, largest pretrigger
      run_capture(4096, 4095, 3'b000, 0, 0, 100000, 0, "max");
      // R2 restart in the middle of a capture, with a sample in the start cycle
      run_capture(2048, 600, 3'b001, 1000, 0, 300, 0, "partial");
      run_capture(2560, 200, 3'b011, 400, 5000, 100000, 1, "restart");
      // R3 invalid configurations
      bad_cfg(2000, 10, "unaligned");
      bad_cfg(1024, 10, "short");
      bad_cfg(2048, 2048, "pre_eq");
      bad_cfg(0, 0, "zero");
      // R2 valid start after a rejection clears the error
      run_capture(3072, 1024, 3'b101, 1500, 99999, 100000, 0, "after_err");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule